// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

The block keeps a group of small write-through caches coherent over one shared bus. Each cache has its own processor-side request port. Read hits are served locally. Read misses and all writes must win the shared bus. A single round-robin arbiter grants the bus to one cache per cycle, so all writes reach the shared backing store one at a time.

When a write wins the bus, it is broadcast on the bus as an invalidate carrying the line address. Every other cache compares that address against its own copy and clears the line's valid bit on a match. The writing cache updates its own copy, and the backing store is written in the same cycle. A later read of that line in another cache therefore misses and fetches the fresh value from the store.

A read that a cache accepts in the same cycle as a matching invalidate from another cache is treated as a miss, so stale data is never returned. Each cache is direct-mapped with one word per line. The low address bits select the line and the remaining bits form the tag.

Top module: `coh_snoop_top`

## Requirements
- R1: `cpu_req_ready[i]` is high exactly when cache i has no outstanding transaction. A request is taken on a cycle where valid and ready are both high. Ready drops on the cycle after a write or a missing read is taken, and rises again after its response. Only one transaction per cache is in flight.
- R2: A read that hits is answered on the cycle after it is taken, with `cpu_rsp_hit`=1 and the cached word, and it does not use the bus. A hit needs the line at index `addr[IDX_W-1:0]` to be valid and its tag to equal `addr[ADDR_W-1:IDX_W]`.
- R3: A read miss requests the bus. On the cycle after its grant, it responds with `cpu_rsp_hit`=0 and the current shared-store word, and the line is filled with that word.
- R4: A write always requests the bus. On its grant cycle it updates the shared store and the cache's own line, which becomes or stays valid. The cache's own broadcast never invalidates its own copy. The response follows one cycle later with hit=0 and `rdata` equal to the written word.
- R5: `bus_inv_valid` is 1 only during the grant cycle of a write, and `bus_inv_addr` then carries the write address. At all other times `bus_inv_valid` is 0.
- R6: On an invalidate, every other cache whose line at that index is valid with a matching tag clears its valid bit. A line at the same index with a different tag stays valid.
- R7: A read taken in the same cycle as a matching invalidate from another cache is handled as a miss (hit=0) and returns the newly written word.
- R8: `bus_grant_vec` is one-hot or zero, and a grant only goes to a cache with a pending bus request.
- R9: After the bus is granted to cache k, the next grant goes to the first requesting cache in the order k+1, k+2, and so on, wrapping round. After reset the search starts at cache 0.
- R10: Reset invalidates every line and clears the shared store to zero. During and just after reset, all ready outputs are 1 and no response, grant or invalidate is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | N_CACHE | Request valid, one bit per cache |
| cpu_req_ready | output | N_CACHE | Request ready, one bit per cache |
| cpu_req_write | input | N_CACHE | 1 = write, 0 = read |
| cpu_req_addr | input | N_CACHE*ADDR_W | Word address; cache i uses bits [i*ADDR_W +: ADDR_W] |
| cpu_req_wdata | input | N_CACHE*DATA_W | Write word; cache i uses bits [i*DATA_W +: DATA_W] |
| cpu_rsp_valid | output | N_CACHE | One-cycle response pulse; cannot be held off |
| cpu_rsp_hit | output | N_CACHE | Response was served from the local copy |
| cpu_rsp_rdata | output | N_CACHE*DATA_W | Read word, or the written word for a write |
| bus_grant_vec | output | N_CACHE | Shared-bus grant this cycle |
| bus_inv_valid | output | 1 | Invalidate broadcast active |
| bus_inv_addr | output | ADDR_W | Address being invalidated |

The request side is valid/ready. A requester keeps valid and its fields stable until it sees ready high at a clock edge. The response side has no back-pressure: the requester must take the pulse when it arrives.

## Verification
Several rules are checked on every cycle by properties:
- the grant is one-hot or zero and only goes to a requester;
- an invalidate only occurs together with a single grant;
- a grant is followed by a non-hit response;
- a hit never appears without a response;
- a read taken against a matching invalidate never reports a hit;
- no requester waits more than one lap of the arbiter.

The bench's scenarios are needed to show the data side, which a local property cannot see:
- that a remote copy really disappears and then refills with the new value;
- that a same-index line with a different tag survives;
- that the writer keeps its copy;
- the exact rotation of grants after a given history.

// File: rtl/coh_pkg.sv
package coh_pkg;

  // Per-cache transaction state.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } node_state_e;

endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
  parameter int N_REQ = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] grant
);
  localparam int PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [PTR_W-1:0] last_q;
  logic [PTR_W-1:0] last_d;

  // Search starts just after the most recent winner and wraps round.
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int k = 1; k <= N_REQ; k++) begin
      int c;
      c = int'(last_q) + k;
      if (c >= N_REQ) c = c - N_REQ;
      if (!found && req[c]) begin
        grant[c] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    last_d = last_q;
    for (int i = 0; i < N_REQ; i++) begin
      if (grant[i]) last_d = PTR_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= PTR_W'(N_REQ - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/coh_backing_mem.sv
module coh_backing_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) store[a] <= '0;
    end else if (wr_en) begin
      store[addr] <= wdata;
    end
  end

  assign rdata = store[addr];
endmodule

// File: rtl/coh_cache_node.sv
module coh_cache_node
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor side
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  // shared bus side
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              own_write,
  output logic [ADDR_W-1:0] own_addr,
  output logic [DATA_W-1:0] own_wdata,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  node_state_e       state;
  logic [LINES-1:0]  line_v;
  logic [TAG_W-1:0]  line_tag [LINES];
  logic [DATA_W-1:0] line_dat [LINES];

  logic              pend_wr;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;

  logic [IDX_W-1:0]  lk_idx, sn_idx, pd_idx;
  logic [TAG_W-1:0]  lk_tag, sn_tag, pd_tag;
  logic              lk_hit, snoop_kill, accept, fast_hit, sn_match, own_turn;

  assign req_ready = (state == ST_IDLE);
  assign bus_req   = (state == ST_WAIT);
  assign own_write = pend_wr;
  assign own_addr  = pend_addr;
  assign own_wdata = pend_wdata;

  always_comb begin
    lk_idx     = req_addr[IDX_W-1:0];
    lk_tag     = req_addr[ADDR_W-1:IDX_W];
    sn_idx     = snoop_addr[IDX_W-1:0];
    sn_tag     = snoop_addr[ADDR_W-1:IDX_W];
    pd_idx     = pend_addr[IDX_W-1:0];
    pd_tag     = pend_addr[ADDR_W-1:IDX_W];
    lk_hit     = line_v[lk_idx] && (line_tag[lk_idx] == lk_tag);
    // A remote invalidate to the same word this cycle wins over the hit.
    snoop_kill = snoop_valid && (snoop_addr == req_addr);
    accept     = req_valid && req_ready;
    fast_hit   = accept && !req_write && lk_hit && !snoop_kill;
    sn_match   = snoop_valid && line_v[sn_idx] && (line_tag[sn_idx] == sn_tag);
    own_turn   = (state == ST_WAIT) && bus_grant;
  end

  // Transaction control and response register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pend_wr    <= 1'b0;
      pend_addr  <= '0;
      pend_wdata <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      if (fast_hit) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_rdata <= line_dat[lk_idx];
      end else if (accept) begin
        state      <= ST_WAIT;
        pend_wr    <= req_write;
        pend_addr  <= req_addr;
        pend_wdata <= req_wdata;
      end else if (own_turn) begin
        state     <= ST_IDLE;
        rsp_valid <= 1'b1;
        rsp_rdata <= pend_wr ? pend_wdata : fill_data;
      end
    end
  end

  // Valid bits: own fill sets, remote invalidate clears (never the same cycle).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_v <= '0;
    end else if (own_turn) begin
      line_v[pd_idx] <= 1'b1;
    end else if (sn_match) begin
      line_v[sn_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (own_turn) begin
      line_tag[pd_idx] <= pd_tag;
      line_dat[pd_idx] <= pend_wr ? pend_wdata : fill_data;
    end
  end
endmodule

// File: rtl/coh_snoop_top.sv
module coh_snoop_top #(
  parameter int N_CACHE = 3,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CACHE-1:0]        cpu_req_valid,
  output logic [N_CACHE-1:0]        cpu_req_ready,
  input  logic [N_CACHE-1:0]        cpu_req_write,
  input  logic [N_CACHE*ADDR_W-1:0] cpu_req_addr,
  input  logic [N_CACHE*DATA_W-1:0] cpu_req_wdata,
  output logic [N_CACHE-1:0]        cpu_rsp_valid,
  output logic [N_CACHE-1:0]        cpu_rsp_hit,
  output logic [N_CACHE*DATA_W-1:0] cpu_rsp_rdata,
  output logic [N_CACHE-1:0]        bus_grant_vec,
  output logic                      bus_inv_valid,
  output logic [ADDR_W-1:0]         bus_inv_addr
);
  logic [N_CACHE-1:0]        node_req;
  logic [N_CACHE-1:0]        node_wr;
  logic [N_CACHE*ADDR_W-1:0] node_addr;
  logic [N_CACHE*DATA_W-1:0] node_wdata;

  logic              sel_write;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic [DATA_W-1:0] mem_rdata;

  coh_rr_arbiter #(.N_REQ(N_CACHE)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (node_req),
    .grant (bus_grant_vec)
  );

  // Bus multiplexer: the single granted cache drives the shared bus.
  always_comb begin
    sel_write = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    for (int i = 0; i < N_CACHE; i++) begin
      if (bus_grant_vec[i]) begin
        sel_write = sel_write | node_wr[i];
        sel_addr  = sel_addr  | node_addr[i*ADDR_W +: ADDR_W];
        sel_wdata = sel_wdata | node_wdata[i*DATA_W +: DATA_W];
      end
    end
  end

  assign bus_inv_valid = sel_write;
  assign bus_inv_addr  = sel_write ? sel_addr : '0;

  coh_backing_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (sel_write),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (mem_rdata)
  );

  for (genvar g = 0; g < N_CACHE; g++) begin : g_node
    coh_cache_node #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_node (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (cpu_req_valid[g]),
      .req_ready   (cpu_req_ready[g]),
      .req_write   (cpu_req_write[g]),
      .req_addr    (cpu_req_addr[g*ADDR_W +: ADDR_W]),
      .req_wdata   (cpu_req_wdata[g*DATA_W +: DATA_W]),
      .rsp_valid   (cpu_rsp_valid[g]),
      .rsp_hit     (cpu_rsp_hit[g]),
      .rsp_rdata   (cpu_rsp_rdata[g*DATA_W +: DATA_W]),
      .bus_req     (node_req[g]),
      .bus_grant   (bus_grant_vec[g]),
      .own_write   (node_wr[g]),
      .own_addr    (node_addr[g*ADDR_W +: ADDR_W]),
      .own_wdata   (node_wdata[g*DATA_W +: DATA_W]),
      .fill_data   (mem_rdata),
      .snoop_valid (sel_write & ~bus_grant_vec[g]),
      .snoop_addr  (sel_addr)
    );
  end
endmodule

// File: rtl/coh_snoop_checker.sv
module coh_snoop_checker #(
  parameter int N_CACHE = 3,
  parameter int ADDR_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_CACHE-1:0]        cpu_req_valid,
  input logic [N_CACHE-1:0]        cpu_req_ready,
  input logic [N_CACHE-1:0]        cpu_req_write,
  input logic [N_CACHE*ADDR_W-1:0] cpu_req_addr,
  input logic [N_CACHE-1:0]        cpu_rsp_valid,
  input logic [N_CACHE-1:0]        cpu_rsp_hit,
  input logic [N_CACHE-1:0]        bus_grant_vec,
  input logic                      bus_inv_valid,
  input logic [ADDR_W-1:0]         bus_inv_addr,
  input logic [N_CACHE-1:0]        bus_req
);
  localparam int CNT_W = $clog2(N_CACHE + 1) + 1;

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant_vec));

  assert_inv_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_inv_valid |-> ($countones(bus_grant_vec) == 1));

  for (genvar j = 0; j < N_CACHE; j++) begin : g_chk
    logic [CNT_W-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              wait_cnt <= '0;
      else if (bus_req[j] && !bus_grant_vec[j]) wait_cnt <= wait_cnt + 1'b1;
      else                                     wait_cnt <= '0;
    end

    assert_grant_to_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant_vec[j] |-> bus_req[j]);

    assert_wait_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req[j] && !bus_grant_vec[j]) |-> (int'(wait_cnt) < N_CACHE - 1));

    assert_grant_gives_miss_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant_vec[j] |=> (cpu_rsp_valid[j] && !cpu_rsp_hit[j]));

    assert_hit_in_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_hit[j] |-> cpu_rsp_valid[j]);

    assert_ready_falls_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_req_ready[j]) |-> $past(cpu_req_valid[j]));

    assert_snoop_beats_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_inv_valid && !bus_grant_vec[j] && cpu_req_valid[j] && cpu_req_ready[j] &&
       !cpu_req_write[j] && (cpu_req_addr[j*ADDR_W +: ADDR_W] == bus_inv_addr))
      |=> !cpu_rsp_hit[j]);
  end
endmodule

bind coh_snoop_top coh_snoop_checker #(.N_CACHE(N_CACHE), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_req_write (cpu_req_write),
  .cpu_req_addr  (cpu_req_addr),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_hit   (cpu_rsp_hit),
  .bus_grant_vec (bus_grant_vec),
  .bus_inv_valid (bus_inv_valid),
  .bus_inv_addr  (bus_inv_addr),
  .bus_req       (node_req)
);

// File: tb/coh_snoop_top_tb_top.sv
`timescale 1ns/1ps
module coh_snoop_top_tb_top;
  localparam int N     = 3;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int IW    = 2;
  localparam int LINES = 1 << IW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_write = '0;
  logic [N*AW-1:0] req_addr  = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    cpu_req_ready, cpu_rsp_valid, cpu_rsp_hit, bus_grant_vec;
  logic [N*DW-1:0] cpu_rsp_rdata;
  logic            bus_inv_valid;
  logic [AW-1:0]   bus_inv_addr;

  always #2.5 clk = ~clk;

  coh_snoop_top #(.N_CACHE(N), .ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(req_write), .cpu_req_addr(req_addr), .cpu_req_wdata(req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_grant_vec(bus_grant_vec), .bus_inv_valid(bus_inv_valid), .bus_inv_addr(bus_inv_addr)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rsp_cyc [N];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit              m_v [N][LINES];
  logic [AW-IW-1:0] m_t [N][LINES];
  logic [DW-1:0]   m_d [N][LINES];
  logic [DW-1:0]   m_mem [DEPTH];
  bit              m_pend [N];
  bit              m_pw [N];
  logic [AW-1:0]   m_pa [N];
  logic [DW-1:0]   m_pd [N];
  int              m_ptr;
  bit              m_rv [N];
  bit              m_rh [N];
  logic [DW-1:0]   m_rd [N];
  string           m_rq [N];

  function automatic int pick();
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (m_ptr + k) % N;
      if (m_pend[c]) return c;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        for (int l = 0; l < LINES; l++) m_v[i][l] = 1'b0;
        m_pend[i] = 1'b0;
        m_rv[i]   = 1'b0;
        m_rh[i]   = 1'b0;
      end
      for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;
      m_ptr = N - 1;
    end else begin
      int g;
      bit inv;
      logic [AW-1:0] ia;
      cyc++;
      g   = pick();
      inv = (g >= 0) && m_pw[g];
      ia  = inv ? m_pa[g] : '0;
      if (inv) m_mem[ia] = m_pd[g];
      for (int i = 0; i < N; i++) begin
        m_rv[i] = 1'b0;
        m_rh[i] = 1'b0;
        if (m_pend[i] && g == i) begin
          int x;
          x = int'(m_pa[i][IW-1:0]);
          m_v[i][x] = 1'b1;
          m_t[i][x] = m_pa[i][AW-1:IW];
          m_d[i][x] = m_pw[i] ? m_pd[i] : m_mem[m_pa[i]];
          m_rv[i]   = 1'b1;
          m_rd[i]   = m_d[i][x];
          m_rq[i]   = m_pw[i] ? "R4" : "R3";
          m_pend[i] = 1'b0;
        end else if (!m_pend[i] && req_valid[i]) begin
          logic [AW-1:0] a;
          int x;
          a = req_addr[i*AW +: AW];
          x = int'(a[IW-1:0]);
          if (!req_write[i] && m_v[i][x] && m_t[i][x] == a[AW-1:IW] && !(inv && ia == a)) begin
            m_rv[i] = 1'b1;
            m_rh[i] = 1'b1;
            m_rd[i] = m_d[i][x];
            m_rq[i] = "R2";
          end else begin
            m_pend[i] = 1'b1;
            m_pw[i]   = req_write[i];
            m_pa[i]   = a;
            m_pd[i]   = req_wdata[i*DW +: DW];
          end
        end
      end
      for (int j = 0; j < N; j++) begin
        int x;
        x = int'(ia[IW-1:0]);
        if (inv && j != g && m_v[j][x] && m_t[j][x] == ia[AW-1:IW]) m_v[j][x] = 1'b0;
      end
      if (g >= 0) m_ptr = g;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      // R10: quiet state while reset is held.
      chk(cpu_req_ready == '1, "R10", "ready in reset", cpu_req_ready, {N{1'b1}});
      chk(cpu_rsp_valid == '0, "R10", "rsp in reset", cpu_rsp_valid, 0);
      chk(bus_grant_vec == '0 && !bus_inv_valid, "R10", "bus in reset",
          {bus_grant_vec, bus_inv_valid}, 0);
    end else if (!done) begin
      int eg;
      bit einv;
      eg   = pick();
      einv = (eg >= 0) && m_pw[eg];
      chk(bus_inv_valid == einv, "R5", "inv_valid", bus_inv_valid, einv);
      if (einv) chk(bus_inv_addr == m_pa[eg], "R5", "inv_addr", bus_inv_addr, m_pa[eg]);
      for (int i = 0; i < N; i++) begin
        chk(cpu_req_ready[i] == !m_pend[i], "R1", $sformatf("ready[%0d]", i),
            cpu_req_ready[i], !m_pend[i]);
        chk(bus_grant_vec[i] == (eg == i), "R9", $sformatf("grant[%0d]", i),
            bus_grant_vec[i], (eg == i));
        chk(cpu_rsp_valid[i] == m_rv[i], "R1", $sformatf("rsp_valid[%0d]", i),
            cpu_rsp_valid[i], m_rv[i]);
        if (m_rv[i]) begin
          chk(cpu_rsp_hit[i] == m_rh[i], m_rq[i], $sformatf("rsp_hit[%0d]", i),
              cpu_rsp_hit[i], m_rh[i]);
          chk(cpu_rsp_rdata[i*DW +: DW] == m_rd[i], m_rq[i], $sformatf("rdata[%0d]", i),
              cpu_rsp_rdata[i*DW +: DW], m_rd[i]);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // One transaction on cache i, with a directed check of its response.
  // exp_hit < 0 skips the hit check.
  task automatic access(input int i, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int exp_hit,
                        input logic [DW-1:0] exp_data, input string tag);
    req_valid[i] = 1'b1;
    req_write[i] = w;
    req_addr[i*AW +: AW]  = a;
    req_wdata[i*DW +: DW] = d;
    while (!cpu_req_ready[i]) @(negedge clk);
    @(negedge clk);
    req_valid[i] = 1'b0;
    while (!cpu_rsp_valid[i]) @(negedge clk);
    rsp_cyc[i] = cyc;
    if (exp_hit >= 0)
      chk(cpu_rsp_hit[i] == exp_hit[0], tag, $sformatf("hit c%0d @%0h", i, a),
          cpu_rsp_hit[i], exp_hit);
    chk(cpu_rsp_rdata[i*DW +: DW] == exp_data, tag, $sformatf("data c%0d @%0h", i, a),
        cpu_rsp_rdata[i*DW +: DW], exp_data);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R10: store starts at zero, first read misses.
    access(0, 0, 8'h10, 16'h0, 0, 16'h0000, "R3");
    // R4: write goes through, writer keeps copy.
    access(0, 1, 8'h10, 16'hAAAA, 0, 16'hAAAA, "R4");
    access(0, 0, 8'h10, 16'h0, 1, 16'hAAAA, "R4");
    // R3 fill in other caches, then R2 local hit.
    access(1, 0, 8'h10, 16'h0, 0, 16'hAAAA, "R3");
    access(2, 0, 8'h10, 16'h0, 0, 16'hAAAA, "R3");
    access(1, 0, 8'h10, 16'h0, 1, 16'hAAAA, "R2");
    // R6: a remote write removes the copies in caches 1 and 2.
    access(0, 1, 8'h10, 16'hBBBB, 0, 16'hBBBB, "R4");
    access(1, 0, 8'h10, 16'h0, 0, 16'hBBBB, "R6");
    access(2, 0, 8'h10, 16'h0, 0, 16'hBBBB, "R6");
    access(0, 0, 8'h10, 16'h0, 1, 16'hBBBB, "R4");
    // R6: same index (0), other tag: cache 1's line survives.
    access(2, 1, 8'h14, 16'hCCCC, 0, 16'hCCCC, "R4");
    access(1, 0, 8'h10, 16'h0, 1, 16'hBBBB, "R6");
    access(2, 0, 8'h10, 16'h0, 0, 16'hBBBB, "R3");
    // R7: read taken in the very cycle the invalidate is on the bus.
    fork
      access(0, 1, 8'h10, 16'hDDDD, 0, 16'hDDDD, "R4");
      begin
        @(negedge clk);
        access(1, 0, 8'h10, 16'h0, 0, 16'hDDDD, "R7");
      end
    join

    // R9: rotation after reset starts at cache 0.
    do_reset();
    fork
      access(0, 1, 8'h20, 16'h1111, 0, 16'h1111, "R9");
      access(1, 1, 8'h21, 16'h2222, 0, 16'h2222, "R9");
      access(2, 1, 8'h22, 16'h3333, 0, 16'h3333, "R9");
    join
    chk(rsp_cyc[1] == rsp_cyc[0] + 1, "R9", "c1 after c0", rsp_cyc[1], rsp_cyc[0] + 1);
    chk(rsp_cyc[2] == rsp_cyc[1] + 1, "R9", "c2 after c1", rsp_cyc[2], rsp_cyc[1] + 1);
    access(1, 1, 8'h23, 16'h4444, 0, 16'h4444, "R9");
    fork
      access(0, 1, 8'h24, 16'h5555, 0, 16'h5555, "R9");
      access(1, 1, 8'h25, 16'h6666, 0, 16'h6666, "R9");
      access(2, 1, 8'h26, 16'h7777, 0, 16'h7777, "R9");
    join
    chk(rsp_cyc[0] == rsp_cyc[2] + 1, "R9", "c0 after c2", rsp_cyc[0], rsp_cyc[2] + 1);
    chk(rsp_cyc[1] == rsp_cyc[0] + 1, "R9", "c1 after c0", rsp_cyc[1], rsp_cyc[0] + 1);
    // R8 is covered by the grant comparison on every cycle above.

    // R10: after a second reset old contents are gone.
    do_reset();
    access(0, 0, 8'h10, 16'h0, 0, 16'h0000, "R10");
    access(1, 0, 8'h24, 16'h0, 0, 16'h0000, "R10");

    done = 1'b1;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule